// File: doc/BRIEF.md
# Fractional Baud Divisor Generator

This block turns the system clock into a 16x oversampling tick for a serial transmitter and receiver pair. The tick period is set by a divisor with an integer part and a 6-bit fractional part, so the average period is the integer value plus the fraction divided by 64 clocks. The fractional part works through an accumulator. Each period adds the fraction to it, and a period in which the accumulator wraps past 64 is one clock longer.

Software writes the two divisor parts into shadow registers, and these writes have no effect on the running rate. A separate line-control write strobe captures both shadows into a pending stage. The pending divisor becomes the active divisor at the next character boundary reported by the serializer. If the active integer part is zero, tick generation is stopped and no character can be in flight, so the pending divisor is applied on the next clock. Each time a divisor is applied, the period counter and the accumulator restart from zero. An integer part of zero keeps the tick output low.

Top module: `frac_baud_gen`

## Requirements
- R1: The fractional shadow keeps only bits 5:0 of the written word. Bits 7:6 of the fractional read-back are always zero.
- R2: After reset, both shadows read zero, the active divisor is zero and `baud_tick` is low.
- R3: Writing either shadow changes the read-back on the next cycle and has no effect on the tick rate in use.
- R4: A `line_ctl_we` pulse captures both shadows into the pending stage. Shadow writes made after the capture do not change the pending value.
- R5: While the active integer part is nonzero, a pending divisor is applied only at a clock edge where `char_done` is high. Until that edge, ticks keep the old spacing.
- R6: While the active integer part is zero, a pending divisor is applied at the first clock edge after its capture, without waiting for `char_done`.
- R7: When a divisor is applied, the period counter and the accumulator restart. The first tick is registered exactly L0 clocks after the apply edge, where L0 is the length of the first period.
- R8: With integer part I and fraction F, period k lasts I+c clocks. Here c is 1 when acc+F is 64 or more and 0 otherwise. The accumulator starts at 0 and becomes (acc+F) mod 64 after each period.
- R9: Any 64 consecutive periods following an apply span 64*I+F clocks, within one clock.
- R10: While the active integer part is zero, `baud_tick` stays low.
- R11: For an integer part of 2 or more, `baud_tick` is high for exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_int_we | input | 1 | Write enable for the integer shadow |
| div_int_wdata | input | INT_W | Integer divisor write data |
| div_frac_we | input | 1 | Write enable for the fractional shadow |
| div_frac_wdata | input | FRAC_REG_W | Fractional divisor write word; only the low 6 bits are kept |
| line_ctl_we | input | 1 | Line-control write strobe; captures the shadows into the pending stage |
| char_done | input | 1 | Character boundary pulse from the serializer |
| div_int_rdata | output | INT_W | Integer shadow read-back |
| div_frac_rdata | output | FRAC_REG_W | Fractional shadow read-back with zero upper bits |
| baud_tick | output | 1 | Single-clock oversampling tick |

## Verification
A corrupted accumulator or a wrong carry shows up as a period one clock too long or too short. The per-period interval comparison catches this within the first period of any fraction whose carry pattern exercises it. A counter that fails to restart on apply moves the first tick away from exactly L0 clocks after the apply edge, so the error is visible in the very first period. A pending stage that leaks early, or that ignores later shadow writes, changes the tick count in the window between the strobe and the boundary, or the spacing right after the boundary. A stuck integer path shows up as ticks during the zero-divisor window.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
   localparam int unsigned FBD_FRAC_BITS = 6;

   typedef enum logic {
      CFG_SETTLED = 1'b0,
      CFG_PENDING = 1'b1
   } cfg_state_e;
endpackage

// File: rtl/fbd_shadow_regs.sv
module fbd_shadow_regs
   import fbd_pkg::*;
#(
   parameter int unsigned INT_W      = 16,
   parameter int unsigned FRAC_W     = 6,
   parameter int unsigned FRAC_REG_W = 8,
   parameter bit          IDLE_APPLY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  int_we,
   input  logic [INT_W-1:0]      int_wdata,
   input  logic                  frac_we,
   input  logic [FRAC_REG_W-1:0] frac_wdata,
   input  logic                  lcr_we,
   input  logic                  char_done,
   output logic [INT_W-1:0]      int_rdata,
   output logic [FRAC_REG_W-1:0] frac_rdata,
   output logic [INT_W-1:0]      act_int,
   output logic [FRAC_W-1:0]     act_frac,
   output logic                  apply
);
   localparam int unsigned PAD_W = (FRAC_REG_W > FRAC_W) ? FRAC_REG_W - FRAC_W : 1;

   logic [INT_W-1:0]  sh_int;
   logic [FRAC_W-1:0] sh_frac;
   logic [INT_W-1:0]  pend_int;
   logic [FRAC_W-1:0] pend_frac;
   cfg_state_e        state;
   logic              idle_ok;

   // elaboration checks
   generate
      if (FRAC_REG_W < FRAC_W) begin : g_bad_reg_w
         $error("FRAC_REG_W must be at least FRAC_W");
      end
      if (INT_W < 2) begin : g_bad_int_w
         $error("INT_W must be at least 2");
      end
   endgenerate

   // shadow registers: software-visible, no effect on the running rate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_int  <= '0;
         sh_frac <= '0;
      end else begin
         if (int_we)  sh_int  <= int_wdata;
         if (frac_we) sh_frac <= frac_wdata[FRAC_W-1:0];
      end
   end

   assign int_rdata = sh_int;

   generate
      if (FRAC_REG_W > FRAC_W) begin : g_pad
         logic unused_frac_hi;
         assign unused_frac_hi = ^frac_wdata[FRAC_REG_W-1:FRAC_W];
         assign frac_rdata     = {{PAD_W{1'b0}}, sh_frac};
      end else begin : g_nopad
         assign frac_rdata = sh_frac;
      end
   endgenerate

   // choice of apply rule when the generator is stopped
   generate
      if (IDLE_APPLY) begin : g_idle_apply
         assign idle_ok = (act_int == '0);
      end else begin : g_boundary_only
         assign idle_ok = 1'b0;
      end
   endgenerate

   assign apply = (state == CFG_PENDING) && (char_done || idle_ok);

   // pending stage and active divisor
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_int  <= '0;
         pend_frac <= '0;
         act_int   <= '0;
         act_frac  <= '0;
         state     <= CFG_SETTLED;
      end else begin
         if (apply) begin
            act_int  <= pend_int;
            act_frac <= pend_frac;
         end
         if (lcr_we) begin
            pend_int  <= sh_int;
            pend_frac <= sh_frac;
            state     <= CFG_PENDING;
         end else if (apply) begin
            state <= CFG_SETTLED;
         end
      end
   end

   // R4: strobe captures the shadow seen in that cycle
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      lcr_we |=> (state == CFG_PENDING) && (pend_int == $past(int_rdata)))
      else $error("a_r4_capture");

   // R5: no change of active divisor in mid-character
   a_r5_hold_midchar: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == CFG_PENDING) && (act_int != '0) && !char_done)
      |=> ($stable(act_int) && $stable(act_frac)))
      else $error("a_r5_hold_midchar");

   generate
      if (IDLE_APPLY) begin : g_idle_chk
         // R6: stopped generator takes the pending value at once
         a_r6_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
            ((state == CFG_PENDING) && (act_int == '0)) |=> (act_int == $past(pend_int)))
            else $error("a_r6_idle_commit");
      end
   endgenerate
endmodule

// File: rtl/fbd_frac_accum.sv
module fbd_frac_accum #(
   parameter int unsigned FRAC_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  logic              advance,
   input  logic [FRAC_W-1:0] frac,
   output logic              carry
);
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W:0]   sum;

   assign sum   = {1'b0, acc} + {1'b0, frac};
   assign carry = sum[FRAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else if (apply) begin
         acc <= '0;
      end else if (advance) begin
         acc <= sum[FRAC_W-1:0];
      end
   end

   // R7: accumulator restarts on every apply
   a_r7_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> (acc == '0))
      else $error("a_r7_acc_clear");

   // R8: accumulator only moves at a period end
   a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply && !advance) |=> $stable(acc))
      else $error("a_r8_acc_hold");
endmodule

// File: rtl/fbd_period_counter.sv
module fbd_period_counter #(
   parameter int unsigned INT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             apply,
   input  logic [INT_W-1:0] act_int,
   input  logic             carry,
   output logic             period_end,
   output logic             tick
);
   localparam int unsigned LEN_W = INT_W + 1;

   logic [INT_W-1:0] cnt;
   logic [LEN_W-1:0] len_w;
   logic [LEN_W-1:0] cnt_nx;
   logic             enabled;

   assign enabled    = (act_int != '0);
   assign len_w      = {1'b0, act_int} + {{INT_W{1'b0}}, carry};
   assign cnt_nx     = {1'b0, cnt} + LEN_W'(1);
   assign period_end = enabled && !apply && (cnt_nx == len_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (apply || !enabled) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (period_end) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt_nx[INT_W-1:0];
         tick <= 1'b0;
      end
   end

   // R7: clean restart of the period count
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> ((cnt == '0) && !tick))
      else $error("a_r7_restart");

   // R10: zero divisor keeps the tick low
   a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (act_int == '0) |=> !tick)
      else $error("a_r10_idle_silent");

   // R11: one-clock pulse for divisors of two and above
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (act_int >= INT_W'(2))) |=> !tick)
      else $error("a_r11_single_pulse");

   // R8: count never reaches the period length
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      enabled |-> ({1'b0, cnt} < len_w))
      else $error("a_r8_cnt_bound");
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
   import fbd_pkg::*;
#(
   parameter int unsigned INT_W      = 16,
   parameter int unsigned FRAC_W     = FBD_FRAC_BITS,
   parameter int unsigned FRAC_REG_W = 8,
   parameter bit          IDLE_APPLY = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  div_int_we,
   input  logic [INT_W-1:0]      div_int_wdata,
   input  logic                  div_frac_we,
   input  logic [FRAC_REG_W-1:0] div_frac_wdata,
   input  logic                  line_ctl_we,
   input  logic                  char_done,
   output logic [INT_W-1:0]      div_int_rdata,
   output logic [FRAC_REG_W-1:0] div_frac_rdata,
   output logic                  baud_tick
);
   logic [INT_W-1:0]  act_int;
   logic [FRAC_W-1:0] act_frac;
   logic              apply;
   logic              carry;
   logic              period_end;

   generate
      if (INT_W > 24) begin : g_bad_int_range
         $error("INT_W above 24 is not supported");
      end
      if (FRAC_W < 1 || FRAC_W > 12) begin : g_bad_frac_range
         $error("FRAC_W must lie in 1..12");
      end
   endgenerate

   fbd_shadow_regs #(
      .INT_W      (INT_W),
      .FRAC_W     (FRAC_W),
      .FRAC_REG_W (FRAC_REG_W),
      .IDLE_APPLY (IDLE_APPLY)
   ) i_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .int_we     (div_int_we),
      .int_wdata  (div_int_wdata),
      .frac_we    (div_frac_we),
      .frac_wdata (div_frac_wdata),
      .lcr_we     (line_ctl_we),
      .char_done  (char_done),
      .int_rdata  (div_int_rdata),
      .frac_rdata (div_frac_rdata),
      .act_int    (act_int),
      .act_frac   (act_frac),
      .apply      (apply)
   );

   fbd_frac_accum #(
      .FRAC_W (FRAC_W)
   ) i_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply   (apply),
      .advance (period_end),
      .frac    (act_frac),
      .carry   (carry)
   );

   fbd_period_counter #(
      .INT_W (INT_W)
   ) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .apply      (apply),
      .act_int    (act_int),
      .carry      (carry),
      .period_end (period_end),
      .tick       (baud_tick)
   );
endmodule

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;
   localparam int INT_W      = 16;
   localparam int FRAC_REG_W = 8;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  div_int_we;
   logic [INT_W-1:0]      div_int_wdata;
   logic                  div_frac_we;
   logic [FRAC_REG_W-1:0] div_frac_wdata;
   logic                  line_ctl_we;
   logic                  char_done;
   logic [INT_W-1:0]      div_int_rdata;
   logic [FRAC_REG_W-1:0] div_frac_rdata;
   logic                  baud_tick;

   always #2 clk = ~clk;

   frac_baud_gen i_frac_baud_gen (
      .clk            (clk),
      .rst_n          (rst_n),
      .div_int_we     (div_int_we),
      .div_int_wdata  (div_int_wdata),
      .div_frac_we    (div_frac_we),
      .div_frac_wdata (div_frac_wdata),
      .line_ctl_we    (line_ctl_we),
      .char_done      (char_done),
      .div_int_rdata  (div_int_rdata),
      .div_frac_rdata (div_frac_rdata),
      .baud_tick      (baud_tick)
   );

   int          vectors = 0;
   int          errors  = 0;
   int unsigned cyc = 0;
   int unsigned tick_count = 0;
   int unsigned last_tick = 0;
   int unsigned prev_tick = 0;
   bit          prev_ok = 1'b0;
   int unsigned first_due = 0;
   int unsigned exp_q[$];
   bit          done = 1'b0;

   // monitor: samples 1 ns after each rising edge
   always @(posedge clk) begin : monitor
      #1;
      cyc++;
      if (baud_tick === 1'b1) begin : got_tick
         int unsigned e;
         tick_count++;
         if (first_due != 0) begin
            vectors++;
            if (cyc != first_due) begin
               errors++;
               $display("FAIL R7 first tick cycle actual=%0d expected=%0d", cyc, first_due);
            end
            first_due = 0;
         end else if (prev_ok && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            vectors++;
            if (cyc - prev_tick != e) begin
               errors++;
               $display("FAIL R8 period length actual=%0d expected=%0d", cyc - prev_tick, e);
            end
         end
         prev_tick = cyc;
         prev_ok   = 1'b1;
         last_tick = cyc;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_int(input int v);
      @(negedge clk); div_int_we = 1'b1; div_int_wdata = INT_W'(v);
      @(negedge clk); div_int_we = 1'b0;
   endtask

   task automatic wr_frac(input int v);
      @(negedge clk); div_frac_we = 1'b1; div_frac_wdata = FRAC_REG_W'(v);
      @(negedge clk); div_frac_we = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); line_ctl_we = 1'b1;
      @(negedge clk); line_ctl_we = 1'b0;
   endtask

   // returns the cycle number of the edge that saw char_done
   task automatic boundary(output int unsigned cb);
      @(negedge clk); char_done = 1'b1;
      @(negedge clk); char_done = 1'b0;
      cb = cyc;
   endtask

   // driver side of the scoreboard: expected period lengths from R8
   task automatic plan_periods(input int unsigned i_part, input int unsigned f_part,
                               input int n, input int unsigned base);
      int unsigned acc;
      acc = 0;
      exp_q.delete();
      for (int k = 0; k < n; k++) begin
         int unsigned s;
         int unsigned l;
         s   = acc + f_part;
         l   = i_part + ((s >= 64) ? 1 : 0);
         acc = s % 64;
         if (k == 0) first_due = base + l;
         else exp_q.push_back(l);
      end
   endtask

   task automatic wait_ticks(input int unsigned target);
      for (int k = 0; k < 20000; k++) begin
         if (tick_count >= target) break;
         @(negedge clk);
      end
   endtask

   task automatic run_frac(input int unsigned i_part, input int unsigned f_part);
      int unsigned cb;
      int unsigned base;
      int unsigned ideal;
      int          diff;
      wr_int(int'(i_part));
      wr_frac(int'(f_part));
      strobe();
      boundary(cb);
      base = tick_count;
      plan_periods(i_part, f_part, 64, cb);
      wait_ticks(base + 64);
      check(exp_q.size() == 0 && first_due == 0, "R8", "periods left unseen",
            exp_q.size(), 0);
      ideal = 64 * i_part + f_part;
      diff  = int'(last_tick - cb) - int'(ideal);
      check(diff >= -1 && diff <= 1, "R9", "span of 64 periods",
            int'(last_tick - cb), int'(ideal));
   endtask

   initial begin : watchdog
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog run incomplete actual=%0d expected=%0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin : driver
      int unsigned t0;
      int unsigned cb;
      int unsigned base;
      rst_n          = 1'b0;
      div_int_we     = 1'b0;
      div_int_wdata  = '0;
      div_frac_we    = 1'b0;
      div_frac_wdata = '0;
      line_ctl_we    = 1'b0;
      char_done      = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state
      check(baud_tick == 1'b0, "R2", "tick after reset", baud_tick, 0);
      check(div_int_rdata == 0, "R2", "int shadow after reset", div_int_rdata, 0);
      check(div_frac_rdata == 0, "R2", "frac shadow after reset", div_frac_rdata, 0);
      repeat (30) @(negedge clk);
      check(tick_count == 0, "R2", "ticks with reset divisor", tick_count, 0);

      // R1, R3: shadow writes
      wr_int(5);
      wr_frac(8'hFF);
      check(div_int_rdata == 5, "R3", "int read-back", div_int_rdata, 5);
      check(div_frac_rdata == 8'h3F, "R1", "frac read-back masked", div_frac_rdata, 8'h3F);
      repeat (40) @(negedge clk);
      check(tick_count == 0, "R3", "ticks before strobe", tick_count, 0);

      // R6, R7: stopped generator takes divisor 5 without a boundary
      wr_frac(0);
      check(div_frac_rdata == 0, "R1", "frac read-back zero", div_frac_rdata, 0);
      strobe();
      base = tick_count;
      plan_periods(5, 0, 10, cyc + 1);
      wait_ticks(base + 10);
      check(exp_q.size() == 0 && first_due == 0, "R6", "idle apply periods seen",
            exp_q.size(), 0);

      // R4, R5: capture 9, overwrite shadow with 11, old rate until boundary
      wr_int(9);
      strobe();
      wr_int(11);
      check(div_int_rdata == 11, "R3", "int read-back after capture", div_int_rdata, 11);
      t0 = tick_count;
      repeat (50) @(negedge clk);
      check(tick_count - t0 == 10, "R5", "ticks in 50 cycles before boundary",
            tick_count - t0, 10);
      boundary(cb);
      base = tick_count;
      plan_periods(9, 0, 6, cb);
      wait_ticks(base + 6);
      check(exp_q.size() == 0 && first_due == 0, "R4", "captured value 9 in use",
            exp_q.size(), 0);

      // R8, R9, R11: fractional patterns
      run_frac(4, 13);
      run_frac(2, 63);
      run_frac(1, 32);
      run_frac(7, 1);
      run_frac(3, 0);

      // R10: zero integer part stops ticks
      wr_int(0);
      strobe();
      boundary(cb);
      t0 = tick_count;
      repeat (100) @(negedge clk);
      check(tick_count == t0, "R10", "ticks with zero divisor", tick_count - t0, 0);

      // R6 again: restart from stopped state with divisor 3
      wr_int(3);
      wr_frac(0);
      strobe();
      base = tick_count;
      plan_periods(3, 0, 8, cyc + 1);
      wait_ticks(base + 8);
      check(exp_q.size() == 0 && first_due == 0, "R6", "restart periods seen",
            exp_q.size(), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule